// File: doc/BRIEF.md
# Serial Control Port with Held-Select Reset

This block is the serial control port of a voice codec. A host frames each access by pulling an active-low select line down. It then clocks bits over one bidirectional data pin with its own data clock, most significant bit first. The port gathers incoming bits into bytes and hands each complete byte to the register file with a one-cycle strobe. When the register file asks for read data, the port shifts a byte back out on the same pin and drives the pin only for that transfer.

The port also counts the data clock rising edges seen while the select line is low. If the host holds select low for sixteen or more data clocks, the port issues a one-cycle device reset pulse when select goes high again. The count uses the data clock alone. All port pins are brought into the block's system clock domain through synchronizers, and both data clock edges are found there. Command decoding and register storage are outside the block.

Top module: `scp_port`

## Requirements
- R1: After the synchronous active-low reset, `byte_valid`, `rst_req`, `dio_oe` and `dio_out` are all 0.
- R2: While `cs_n` is low, `dio_in` is sampled on each rising edge of `dclk`. After eight samples, `byte_valid` is high for exactly one cycle and `byte_out` holds the eight bits, the first sampled bit in bit 7.
- R3: When `cs_n` rises, any partial byte is dropped, and the next frame starts a new byte at bit 7.
- R4: While `cs_n` is high, toggling `dclk` and `dio_in` produces no byte strobe and no reset pulse.
- R5: If at least 16 rising `dclk` edges occurred while `cs_n` was low, one single-cycle `rst_req` pulse follows the rise of `cs_n`. It is never raised while select is low.
- R6: A frame with 15 or fewer rising `dclk` edges produces no `rst_req`.
- R7: The low-time counter saturates. A frame of several hundred clocks gives exactly one `rst_req`, the same as a frame of 16.
- R8: A `tx_load` pulse while `cs_n` is low captures `tx_byte`. On the next eight falling `dclk` edges `dio_out` presents bit 7 down to bit 0. `dio_oe` rises at the first of those edges and falls at the ninth falling edge.
- R9: `dio_oe` is 0 whenever `cs_n` has been high for more than the synchronizer delay, which ends any transfer in progress. A `tx_load` given while `cs_n` is high is ignored.
- R10: Several bytes sent back to back in one frame each give their own strobe, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| dclk | input | 1 | Host data clock |
| dio_in | input | 1 | Data pin input level |
| tx_load | input | 1 | Register file asks to send `tx_byte` |
| tx_byte | input | DATA_W | Read data to send |
| dio_out | output | 1 | Data pin output level |
| dio_oe | output | 1 | Data pin output enable |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_out | output | DATA_W | Assembled byte |
| rst_req | output | 1 | One-cycle device reset pulse |

## Verification
A bit counter that is out of step shows up at once as a byte built from the wrong bits or a strobe in the wrong frame. The bench sees it at the end of that same frame. A low-time counter that wraps or fails to clear shows up as a missing, extra or early `rst_req` within a few system clocks of select rising. The bench tests this at 15, 16 and several hundred clocks. A wrong transmit state shows up as a shifted byte or an enable that is too long or too short within the same transfer. The bench compares that transfer against all 256 byte values.

// File: rtl/scp_pkg.sv
// Shared constants for the serial control port.
// Assumes: reset levels of the synchronized pins match an idle host.
package scp_pkg;
    localparam logic IDLE_CS   = 1'b1;
    localparam logic IDLE_DCLK = 1'b0;
    localparam logic IDLE_DATA = 1'b0;
endpackage

// File: rtl/scp_sync.sv
// Multi-bit synchronizer chain. Each bit is synchronized on its own, and
// each bit has its own reset value.
// Assumes: inputs are slow compared with clk (data clock period >= 12 clk).
module scp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Stage s: copy the previous stage, or the raw input for stage 0.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= rst_val;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scp_rx.sv
// Receive shifter: builds MSB-first bytes from data bits sampled on the
// rising data clock edge, and strobes each completed byte for one cycle.
// Assumes: rise is a single-cycle event, already gated by select.
module scp_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              rise,
    input  logic              din,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_out
);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic [BIT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;

    // Shift bits in and count them. Clear while select is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (rise) begin
            shreg   <= {shreg[DATA_W-2:0], din};
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        end
    end

    // Present the completed byte with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_valid <= 1'b0;
            byte_out   <= '0;
        end else begin
            byte_valid <= cs_act && rise && (bit_cnt == LAST_BIT);
            if (cs_act && rise && (bit_cnt == LAST_BIT))
                byte_out <= {shreg[DATA_W-2:0], din};
        end
    end
endmodule

// File: rtl/scp_tx.sv
// Transmit shifter: once loaded, drives one byte MSB first, a new bit on
// each falling data clock edge, and enables the pin for that byte only.
// Assumes: fall is a single-cycle event, already gated by select.
module scp_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              fall,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              dio_out,
    output logic              dio_oe
);
    localparam int LEFT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] tx_sh;
    logic              pending;
    logic [LEFT_W-1:0] bits_left;

    // Load, shift out and release the pin. Select idle aborts everything.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            tx_sh     <= '0;
            pending   <= 1'b0;
            bits_left <= '0;
            dio_out   <= 1'b0;
            dio_oe    <= 1'b0;
        end else if (tx_load) begin
            tx_sh   <= tx_byte;
            pending <= 1'b1;
            dio_oe  <= 1'b0;
        end else if (fall) begin
            if (pending) begin
                dio_out   <= tx_sh[DATA_W-1];
                tx_sh     <= tx_sh << 1;
                dio_oe    <= 1'b1;
                pending   <= 1'b0;
                bits_left <= LEFT_W'(DATA_W - 1);
            end else if (dio_oe) begin
                if (bits_left == '0) begin
                    dio_oe  <= 1'b0;
                    dio_out <= 1'b0;
                end else begin
                    dio_out   <= tx_sh[DATA_W-1];
                    tx_sh     <= tx_sh << 1;
                    bits_left <= bits_left - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/scp_hold.sv
// Select-held timer: counts rising data clock edges while select is low.
// The count saturates at the limit. When select is released after the
// limit was reached, one reset pulse is issued.
// Assumes: rise is a single-cycle event, already gated by select.
module scp_hold #(
    parameter int RST_CYCLES = 16,
    parameter int CNT_W      = $clog2(RST_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_act,
    input  logic             rise,
    output logic             rst_req,
    output logic [CNT_W-1:0] low_cnt
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RST_CYCLES);

    logic cs_prev;

    // Saturating count of data clocks while select is low.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) low_cnt <= '0;
        else if (rise && low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
    end

    // Detect select release and decide on the reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            cs_prev <= cs_act;
            rst_req <= cs_prev && !cs_act && (low_cnt >= LIMIT);
        end
    end
endmodule

// File: rtl/scp_port.sv
// Serial control port top: synchronizes the host pins, finds the data
// clock edges, and drives the receive, transmit and held-select logic.
// Assumes: the data clock is at least 12 times slower than clk.
module scp_port #(
    parameter int DATA_W      = 8,
    parameter int RST_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              dclk,
    input  logic              dio_in,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              dio_out,
    output logic              dio_oe,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_out,
    output logic              rst_req
);
    import scp_pkg::*;
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    logic [2:0]       pins_s;
    logic             cs_s, dclk_s, din_s, dclk_d;
    logic             cs_act, rise, fall;
    logic [CNT_W-1:0] low_cnt;

    scp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rst_val({IDLE_CS, IDLE_DCLK, IDLE_DATA}),
        .d      ({cs_n, dclk, dio_in}),
        .q      (pins_s)
    );
    assign {cs_s, dclk_s, din_s} = pins_s;

    // Delay the synchronized data clock by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dclk_d <= IDLE_DCLK;
        else dclk_d <= dclk_s;
    end

    assign cs_act = !cs_s;
    assign rise   = cs_act && dclk_s && !dclk_d;
    assign fall   = cs_act && !dclk_s && dclk_d;

    scp_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rise(rise), .din(din_s),
        .byte_valid(byte_valid), .byte_out(byte_out)
    );

    scp_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .fall(fall),
        .tx_load(tx_load), .tx_byte(tx_byte),
        .dio_out(dio_out), .dio_oe(dio_oe)
    );

    scp_hold #(.RST_CYCLES(RST_CYCLES), .CNT_W(CNT_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rise(rise),
        .rst_req(rst_req), .low_cnt(low_cnt)
    );
endmodule

// File: rtl/scp_port_chk.sv
// Property checker for the serial control port, bound into every instance.
module scp_port_chk #(
    parameter int RST_CYCLES = 16,
    parameter int CNT_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_act,
    input logic             byte_valid,
    input logic             rst_req,
    input logic             dio_oe,
    input logic [CNT_W-1:0] low_cnt
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid); // R2
    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R5
    AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !cs_act); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= CNT_W'(RST_CYCLES)); // R7
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_act) |=> !dio_oe); // R9
    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && !$past(cs_act)) |-> !dio_oe); // R9
endmodule

bind scp_port scp_port_chk #(.RST_CYCLES(RST_CYCLES), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .byte_valid(byte_valid),
    .rst_req(rst_req), .dio_oe(dio_oe), .low_cnt(low_cnt)
);

// File: tb/scp_port_tb.sv
// Bench for scp_port: byte sweeps in both directions plus select-hold cases.
module scp_port_tb;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, dclk = 1'b0, dio_in = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       dio_out, dio_oe, byte_valid, rst_req;
    logic [7:0] byte_out;

    int checks = 0, errors = 0;
    int nvalid = 0, nrst = 0;
    logic [7:0] hist [0:1023];

    always #2.5 clk = ~clk;

    scp_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk), .dio_in(dio_in),
        .tx_load(tx_load), .tx_byte(tx_byte), .dio_out(dio_out), .dio_oe(dio_oe),
        .byte_valid(byte_valid), .byte_out(byte_out), .rst_req(rst_req)
    );

    // Record strobes and reset pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                hist[nvalid % 1024] = byte_out;
                nvalid++;
            end
            if (rst_req) nrst++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic din, output logic o, output logic oe);
        dio_in = din;
        wclk(HALF);
        o  = dio_out;
        oe = dio_oe;
        dclk = 1'b1;
        wclk(HALF);
        dclk = 1'b0;
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        wclk(HALF);
    endtask

    task automatic cs_hi();
        cs_n = 1'b1;
        wclk(2 * HALF);
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic o, oe;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], o, oe);
    endtask

    task automatic idle_bits(input int n);
        logic o, oe;
        for (int i = 0; i < n; i++) bit_cycle(1'b0, o, oe);
    endtask

    task automatic pulse_load(input logic [7:0] b);
        tx_byte = b;
        tx_load = 1'b1;
        wclk(1);
        tx_load = 1'b0;
    endtask

    initial begin
        wclk(400000);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n0, r0;
        logic o, oe;
        logic [7:0] got;
        int oe_cnt;
        bit ok;

        // R1: reset state.
        wclk(5);
        chk(byte_valid == 0 && rst_req == 0, "R1 strobes", {byte_valid, rst_req}, 0);
        chk(dio_oe == 0 && dio_out == 0, "R1 pin", {dio_oe, dio_out}, 0);
        rst_n = 1'b1;
        wclk(5);
        chk(byte_valid == 0 && rst_req == 0 && dio_oe == 0, "R1 after release",
            {byte_valid, rst_req, dio_oe}, 0);

        // R4: clocks while select idle have no effect.
        n0 = nvalid; r0 = nrst;
        for (int i = 0; i < 20; i++) bit_cycle(i[0], o, oe);
        wclk(8);
        chk(nvalid == n0, "R4 no byte", nvalid - n0, 0);
        chk(nrst == r0, "R4 no reset", nrst - r0, 0);

        // R2 and R6: every byte value in its own short frame.
        for (int v = 0; v < 256; v++) begin
            n0 = nvalid; r0 = nrst;
            cs_lo();
            send_byte(8'(v));
            cs_hi();
            got = hist[n0 % 1024];
            chk(nvalid == n0 + 1 && got == 8'(v), "R2 byte", got, v);
            chk(nrst == r0, "R6 short frame", nrst - r0, 0);
        end

        // R10 and R5: three bytes in one frame, 24 clocks.
        n0 = nvalid; r0 = nrst;
        cs_lo();
        send_byte(8'hA5); send_byte(8'h3C); send_byte(8'hF0);
        chk(nrst == r0, "R5 no pulse while low", nrst - r0, 0);
        cs_hi();
        chk(nvalid == n0 + 3, "R10 count", nvalid - n0, 3);
        chk(hist[n0 % 1024] == 8'hA5, "R10 first", hist[n0 % 1024], 8'hA5);
        chk(hist[(n0 + 1) % 1024] == 8'h3C, "R10 second", hist[(n0 + 1) % 1024], 8'h3C);
        chk(hist[(n0 + 2) % 1024] == 8'hF0, "R10 third", hist[(n0 + 2) % 1024], 8'hF0);
        chk(nrst == r0 + 1, "R5 long frame", nrst - r0, 1);

        // R3: partial byte dropped, next frame aligned.
        n0 = nvalid;
        cs_lo(); send_byte(8'hFF); cs_n = 1'b1; wclk(1);
        cs_lo();
        for (int i = 0; i < 5; i++) bit_cycle(1'b1, o, oe);
        cs_hi();
        chk(nvalid == n0 + 1, "R3 partial not strobed", nvalid - n0, 1);
        n0 = nvalid;
        cs_lo(); send_byte(8'h96); cs_hi();
        chk(nvalid == n0 + 1 && hist[n0 % 1024] == 8'h96, "R3 realigned",
            hist[n0 % 1024], 8'h96);

        // R6 boundary: 15 clocks, no reset.
        r0 = nrst;
        cs_lo(); idle_bits(15); cs_hi();
        chk(nrst == r0, "R6 fifteen clocks", nrst - r0, 0);

        // R5 boundary: 16 clocks, one reset.
        r0 = nrst;
        cs_lo(); idle_bits(16); cs_hi();
        chk(nrst == r0 + 1, "R5 sixteen clocks", nrst - r0, 1);

        // R7: long hold saturates and still gives exactly one pulse.
        r0 = nrst;
        cs_lo(); idle_bits(300); cs_hi();
        chk(nrst == r0 + 1, "R7 saturated hold", nrst - r0, 1);

        // R8: transmit every byte value.
        for (int v = 0; v < 256; v++) begin
            cs_lo();
            pulse_load(8'(v));
            ok = 1; got = '0; oe_cnt = 0;
            for (int k = 0; k < 10; k++) begin
                bit_cycle(1'b0, o, oe);
                if (oe) oe_cnt++;
                if (k >= 1 && k <= 8) begin
                    got = {got[6:0], o};
                    if (!oe) ok = 0;
                end else if (oe) ok = 0;
            end
            cs_hi();
            chk(ok && oe_cnt == 8 && got == 8'(v), "R8 transmit", {oe_cnt[7:0], got}, {8'd8, 8'(v)});
        end

        // R9: select release aborts a transfer.
        cs_lo();
        pulse_load(8'hFF);
        for (int k = 0; k < 4; k++) bit_cycle(1'b0, o, oe);
        chk(dio_oe == 1, "R9 driving mid transfer", dio_oe, 1);
        cs_hi();
        chk(dio_oe == 0, "R9 released on select high", dio_oe, 0);

        // R9: load while idle is ignored.
        pulse_load(8'hFF);
        cs_lo();
        oe_cnt = 0;
        for (int k = 0; k < 4; k++) begin
            bit_cycle(1'b0, o, oe);
            if (oe) oe_cnt++;
        end
        cs_hi();
        chk(oe_cnt == 0, "R9 idle load ignored", oe_cnt, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule